// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is the engine of one DMA channel that always moves data in the same direction. Software writes a list of transfer elements into a dedicated descriptor memory, one element after another. Each element gives a source address, a destination address, a byte count and a control word. Software then rings a doorbell. The engine reads the elements one at a time, starting at the list base address. For each valid data element it issues one block copy on a simple memory-to-memory copy port and waits for that copy to finish.

The control word carries a cycle bit. It tells a freshly written batch of elements apart from a stale one. The engine keeps an expected cycle value, which starts at 1. An element whose cycle bit differs from the expected value stops the walk quietly. A link element ends the batch, flips the expected cycle value and loads its pointer as the new list base, so software refills the region with the opposite cycle bit each time. Interrupt-enable flags on an element raise the done interrupt once its copy completes. A zero byte count is treated as a fault: the engine raises the abort interrupt and stops the channel.

Top module: `lldma_walker`

## Requirements
- R1: After reset, cp_req, desc_rd_en, irq_done and irq_abort are 0, and the channel status register (offset 4) reads 4: bit 0 busy = 0, bit 1 error = 0, bit 2 expected cycle bit = 1.
- R2: Any write to the doorbell register (offset 2) while the channel is idle and has no error starts a walk. The first element is read at the base address from registers 0 (low 32 bits) and 1 (high 32 bits). Each later element is read ELEM_BYTES (32) bytes after the previous one. Every read strobe lasts exactly one cycle.
- R3: An element whose cycle bit (control bit 0) equals the expected value produces exactly one copy request. The request carries the element's source, destination and byte count, and holds them stable until cp_done. cp_write always equals the CH_WRITE parameter. The element layout in desc_rd_data is: control in bits [31:0], byte count in [63:32], source in [127:64], destination in [191:128].
- R4: An element whose cycle bit differs from the expected value sends the channel idle. It issues no copy, raises no interrupt and leaves the expected bit unchanged. The next doorbell reads again from the base address.
- R5: A link element (control bit 1 set, cycle bit matching) issues no copy and sends the channel idle. It flips the expected cycle bit in status bit 2, and its 64-bit pointer (held in the source field) becomes the base address.
- R6: When the copy of an element with control bit 3 or control bit 4 set completes, interrupt status bit 0 and irq_done are set. An element with neither bit set leaves them unchanged.
- R7: A matching data element with a byte count of 0 issues no copy. It sets the error bit (status bit 1), interrupt status bit 1 and irq_abort, and stops the channel.
- R8: While the error is set, doorbell writes are ignored. Writing 1 to interrupt status bit 1 clears both the abort interrupt and the error.
- R9: Interrupt status bits (offset 3) clear only when written with 1. Writing 0 to a bit leaves it unchanged.
- R10: The full 32-bit byte count, including 0xFFFFFFFF, and both 64-bit addresses reach the copy port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, one cycle later |
| desc_rd_en | output | 1 | Descriptor memory read strobe |
| desc_rd_addr | output | 64 | Byte address of the element being read |
| desc_rd_data | input | 192 | Element returned one cycle after the strobe |
| cp_req | output | 1 | Copy request, held until cp_done |
| cp_write | output | 1 | Fixed channel direction (1 = write) |
| cp_src | output | 64 | Copy source address |
| cp_dst | output | 64 | Copy destination address |
| cp_len | output | 32 | Copy byte count |
| cp_done | input | 1 | One-cycle copy completion |
| irq_done | output | 1 | Done interrupt, level |
| irq_abort | output | 1 | Abort interrupt, level |

## Verification
The main walk is run over lists of one to four data elements. Each pass refills the memory with the opposite cycle bit, and byte counts and addresses vary with the pass and the element index. This separates correct address stepping, field slicing and cycle-bit flipping from designs that only handle the first element or a single pass. Four more patterns follow. A stale list (old cycle bit) must produce one read and nothing else. A list without interrupt flags must finish silently. A list with a zero byte count in the middle must abort after exactly one copy. A repaired list with a maximum byte count and a link pointer to a new base must pass those values through unchanged.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int CTL_W = 32;

  // control word bit positions
  localparam int CTL_CB   = 0;
  localparam int CTL_LINK = 1;
  localparam int CTL_LIE  = 3;
  localparam int CTL_RIE  = 4;
  localparam logic [CTL_W-1:0] CTL_USED =
      (CTL_W'(1) << CTL_CB) | (CTL_W'(1) << CTL_LINK) |
      (CTL_W'(1) << CTL_LIE) | (CTL_W'(1) << CTL_RIE);

  // register offsets
  localparam logic [2:0] RG_BASE_LO = 3'd0;
  localparam logic [2:0] RG_BASE_HI = 3'd1;
  localparam logic [2:0] RG_BELL    = 3'd2;
  localparam logic [2:0] RG_IRQ     = 3'd3;
  localparam logic [2:0] RG_STAT    = 3'd4;

  localparam int IRQ_DONE  = 0;
  localparam int IRQ_ABORT = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_COPY
  } walk_state_t;

endpackage

// File: rtl/lldma_elem_decode.sv
module lldma_elem_decode
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  localparam int DESC_W = CTL_W + LEN_W + 2 * ADDR_W
) (
  input  logic [DESC_W-1:0] desc,
  input  logic              exp_cb,
  output logic              cb_ok,
  output logic              is_link,
  output logic              irq_req,
  output logic              len_zero,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [LEN_W-1:0]  len
);

  logic [CTL_W-1:0] ctrl;
  logic             ctl_unused;

  assign ctrl     = desc[CTL_W-1:0];
  assign len      = desc[CTL_W +: LEN_W];
  assign src      = desc[CTL_W + LEN_W +: ADDR_W];
  assign dst      = desc[CTL_W + LEN_W + ADDR_W +: ADDR_W];

  assign cb_ok    = (ctrl[CTL_CB] == exp_cb);
  assign is_link  = ctrl[CTL_LINK];
  assign irq_req  = ctrl[CTL_LIE] | ctrl[CTL_RIE];
  assign len_zero = (len == '0);

  // reserved control bits carry no meaning
  assign ctl_unused = ^(ctrl & ~CTL_USED);

endmodule

// File: rtl/lldma_walk_fsm.sv
module lldma_walk_fsm
  import lldma_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LEN_W      = 32,
  parameter int ELEM_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  // decoded element
  input  logic              cb_ok,
  input  logic              is_link,
  input  logic              irq_req,
  input  logic              len_zero,
  input  logic [ADDR_W-1:0] el_src,
  input  logic [ADDR_W-1:0] el_dst,
  input  logic [LEN_W-1:0]  el_len,
  // descriptor read
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  // copy port
  output logic              cp_req,
  output logic [ADDR_W-1:0] cp_src,
  output logic [ADDR_W-1:0] cp_dst,
  output logic [LEN_W-1:0]  cp_len,
  input  logic              cp_done,
  // status
  output logic              exp_cb,
  output logic              busy,
  output logic              done_pulse,
  output logic              abort_pulse,
  output logic              link_pulse,
  output logic [ADDR_W-1:0] link_ptr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ELEM_BYTES);

  walk_state_t state;
  logic        irq_pend;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rd_en       <= 1'b0;
      rd_addr     <= '0;
      cp_req      <= 1'b0;
      cp_src      <= '0;
      cp_dst      <= '0;
      cp_len      <= '0;
      exp_cb      <= 1'b1;
      irq_pend    <= 1'b0;
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
      link_pulse  <= 1'b0;
      link_ptr    <= '0;
    end else begin
      rd_en       <= 1'b0;
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
      link_pulse  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            rd_addr <= base_addr;
            rd_en   <= 1'b1;
            state   <= ST_RD;
          end
        end
        ST_RD: begin
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!cb_ok) begin
            state <= ST_IDLE;
          end else if (is_link) begin
            exp_cb     <= ~exp_cb;
            link_ptr   <= el_src;
            link_pulse <= 1'b1;
            state      <= ST_IDLE;
          end else if (len_zero) begin
            abort_pulse <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            cp_req   <= 1'b1;
            cp_src   <= el_src;
            cp_dst   <= el_dst;
            cp_len   <= el_len;
            irq_pend <= irq_req;
            state    <= ST_COPY;
          end
        end
        ST_COPY: begin
          if (cp_done) begin
            cp_req     <= 1'b0;
            done_pulse <= irq_pend;
            rd_addr    <= rd_addr + STEP;
            rd_en      <= 1'b1;
            state      <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int ADDR_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic              exp_cb,
  input  logic              done_pulse,
  input  logic              abort_pulse,
  input  logic              link_pulse,
  input  logic [ADDR_W-1:0] link_ptr,
  output logic [ADDR_W-1:0] base_addr,
  output logic              start,
  output logic              irq_done,
  output logic              irq_abort
);

  logic wr_base_lo, wr_base_hi, wr_bell, wr_irq;

  assign wr_base_lo = wr_en && (addr == RG_BASE_LO);
  assign wr_base_hi = wr_en && (addr == RG_BASE_HI);
  assign wr_bell    = wr_en && (addr == RG_BELL);
  assign wr_irq     = wr_en && (addr == RG_IRQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      start     <= 1'b0;
      irq_done  <= 1'b0;
      irq_abort <= 1'b0;
      rdata     <= '0;
    end else begin
      if (link_pulse) begin
        base_addr <= link_ptr;
      end else begin
        if (wr_base_lo) base_addr[REG_W-1:0]      <= wdata;
        if (wr_base_hi) base_addr[ADDR_W-1:REG_W] <= wdata;
      end

      // abort status doubles as the channel error flag
      start <= wr_bell && !busy && !irq_abort;

      if (done_pulse)
        irq_done <= 1'b1;
      else if (wr_irq && wdata[IRQ_DONE])
        irq_done <= 1'b0;

      if (abort_pulse)
        irq_abort <= 1'b1;
      else if (wr_irq && wdata[IRQ_ABORT])
        irq_abort <= 1'b0;

      case (addr)
        RG_BASE_LO: rdata <= base_addr[REG_W-1:0];
        RG_BASE_HI: rdata <= base_addr[ADDR_W-1:REG_W];
        RG_IRQ:     rdata <= REG_W'({irq_abort, irq_done});
        RG_STAT:    rdata <= REG_W'({exp_cb, irq_abort, busy});
        default:    rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
  import lldma_pkg::*;
#(
  parameter int   REG_W      = 32,
  parameter int   LEN_W      = 32,
  parameter int   ELEM_BYTES = 32,
  parameter logic CH_WRITE   = 1'b1,
  localparam int  ADDR_W     = 2 * REG_W,
  localparam int  DESC_W     = CTL_W + LEN_W + 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              desc_rd_en,
  output logic [ADDR_W-1:0] desc_rd_addr,
  input  logic [DESC_W-1:0] desc_rd_data,
  output logic              cp_req,
  output logic              cp_write,
  output logic [ADDR_W-1:0] cp_src,
  output logic [ADDR_W-1:0] cp_dst,
  output logic [LEN_W-1:0]  cp_len,
  input  logic              cp_done,
  output logic              irq_done,
  output logic              irq_abort
);

  logic              cb_ok, is_link, irq_req, len_zero;
  logic [ADDR_W-1:0] el_src, el_dst, base_addr, link_ptr;
  logic [LEN_W-1:0]  el_len;
  logic              exp_cb, busy, start;
  logic              done_pulse, abort_pulse, link_pulse;

  assign cp_write = CH_WRITE;

  lldma_elem_decode #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_decode (
    .desc    (desc_rd_data),
    .exp_cb  (exp_cb),
    .cb_ok   (cb_ok),
    .is_link (is_link),
    .irq_req (irq_req),
    .len_zero(len_zero),
    .src     (el_src),
    .dst     (el_dst),
    .len     (el_len)
  );

  lldma_walk_fsm #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .ELEM_BYTES(ELEM_BYTES)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .base_addr  (base_addr),
    .cb_ok      (cb_ok),
    .is_link    (is_link),
    .irq_req    (irq_req),
    .len_zero   (len_zero),
    .el_src     (el_src),
    .el_dst     (el_dst),
    .el_len     (el_len),
    .rd_en      (desc_rd_en),
    .rd_addr    (desc_rd_addr),
    .cp_req     (cp_req),
    .cp_src     (cp_src),
    .cp_dst     (cp_dst),
    .cp_len     (cp_len),
    .cp_done    (cp_done),
    .exp_cb     (exp_cb),
    .busy       (busy),
    .done_pulse (done_pulse),
    .abort_pulse(abort_pulse),
    .link_pulse (link_pulse),
    .link_ptr   (link_ptr)
  );

  lldma_regs #(
    .REG_W(REG_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .busy       (busy),
    .exp_cb     (exp_cb),
    .done_pulse (done_pulse),
    .abort_pulse(abort_pulse),
    .link_pulse (link_pulse),
    .link_ptr   (link_ptr),
    .base_addr  (base_addr),
    .start      (start),
    .irq_done   (irq_done),
    .irq_abort  (irq_abort)
  );

endmodule

// File: rtl/lldma_walker_chk.sv
module lldma_walker_chk #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              desc_rd_en,
  input logic              cp_req,
  input logic              cp_done,
  input logic [ADDR_W-1:0] cp_src,
  input logic [ADDR_W-1:0] cp_dst,
  input logic [LEN_W-1:0]  cp_len,
  input logic              irq_done,
  input logic              irq_abort
);

  assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
    desc_rd_en |=> !desc_rd_en);

  assert_copy_args_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cp_req && !cp_done) |=> (cp_req && $stable(cp_src) && $stable(cp_dst) && $stable(cp_len)));

  assert_read_copy_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(desc_rd_en && cp_req));

  assert_done_after_copy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_done) |-> $past(cp_done, 2));

  assert_no_zero_copy_R7: assert property (@(posedge clk) disable iff (rst)
    cp_req |-> (cp_len != '0));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_abort) |-> !cp_req);

endmodule

bind lldma_walker lldma_walker_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .desc_rd_en(desc_rd_en),
  .cp_req    (cp_req),
  .cp_done   (cp_done),
  .cp_src    (cp_src),
  .cp_dst    (cp_dst),
  .cp_len    (cp_len),
  .irq_done  (irq_done),
  .irq_abort (irq_abort)
);

// File: tb/test_lldma_walker.sv
module test_lldma_walker;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] MEM_BASE = 64'h1000;
  localparam int MEM_N = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic         desc_rd_en;
  logic [63:0]  desc_rd_addr;
  logic [191:0] desc_rd_data = '0;
  logic         cp_req, cp_write;
  logic [63:0]  cp_src, cp_dst;
  logic [31:0]  cp_len;
  logic         cp_done = 1'b0;
  logic         irq_done, irq_abort;

  logic [191:0] mem [0:MEM_N-1];

  int nchk = 0;
  int nerr = 0;

  logic [63:0] rd_log [0:15];
  logic [63:0] src_log [0:15];
  logic [63:0] dst_log [0:15];
  logic [31:0] len_log [0:15];
  int rd_cnt = 0;
  int cp_cnt = 0;
  int lat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lldma_walker i_lldma_walker (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .desc_rd_en  (desc_rd_en),
    .desc_rd_addr(desc_rd_addr),
    .desc_rd_data(desc_rd_data),
    .cp_req      (cp_req),
    .cp_write    (cp_write),
    .cp_src      (cp_src),
    .cp_dst      (cp_dst),
    .cp_len      (cp_len),
    .cp_done     (cp_done),
    .irq_done    (irq_done),
    .irq_abort   (irq_abort)
  );

  // descriptor memory, one cycle read latency
  always @(posedge clk) begin
    if (desc_rd_en)
      desc_rd_data <= mem[6'((desc_rd_addr - MEM_BASE) >> 5)];
  end

  // read monitor and copy responder
  always @(negedge clk) begin
    if (desc_rd_en && rd_cnt < 16) begin
      rd_log[rd_cnt] = desc_rd_addr;
      rd_cnt++;
    end
    if (cp_req && !cp_done) begin
      if (lat == 2) begin
        cp_done = 1'b1;
        lat = 0;
        if (cp_cnt < 16) begin
          src_log[cp_cnt] = cp_src;
          dst_log[cp_cnt] = cp_dst;
          len_log[cp_cnt] = cp_len;
        end
        cp_cnt++;
      end else begin
        lat++;
      end
    end else begin
      cp_done = 1'b0;
    end
  end

  function automatic logic [191:0] mk(input logic cb, input logic link,
                                      input logic lie, input logic rie,
                                      input logic [31:0] len,
                                      input logic [63:0] src,
                                      input logic [63:0] dst);
    logic [31:0] ctl;
    ctl = {27'd0, rie, lie, 1'b0, link, cb};
    return {dst, src, len, ctl};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic ring();
    rd_cnt = 0;
    cp_cnt = 0;
    reg_write(3'd2, 32'd1);
    repeat (90) @(negedge clk);
  endtask

  task automatic run_all();
    logic [31:0] rv;
    logic        exp_cb;
    int          n;
    logic [63:0] s, d;
    logic [31:0] l;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cp_req", 64'(cp_req), 64'd0);
    chk("R1 desc_rd_en", 64'(desc_rd_en), 64'd0);
    chk("R1 irq_done", 64'(irq_done), 64'd0);
    chk("R1 irq_abort", 64'(irq_abort), 64'd0);
    reg_read(3'd4, rv);
    chk("R1 status", 64'(rv), 64'd4);

    reg_write(3'd0, MEM_BASE[31:0]);
    reg_write(3'd1, MEM_BASE[63:32]);
    exp_cb = 1'b1;

    // sweep list lengths 1..4, alternating cycle bit per refill
    for (int p = 0; p < 4; p++) begin
      n = p + 1;
      for (int i = 0; i < n; i++) begin
        s = {32'h8000_0000 | 32'(p), 32'(i * 64)};
        d = {32'h4000_0000 + 32'(p), 32'(i * 64 + 7)};
        l = 32'((i + 1) * (p + 3));
        mem[i] = mk(exp_cb, 1'b0, (i == n-1) && (p % 2 == 0),
                    (i == n-1) && (p % 2 == 1), l, s, d);
      end
      mem[n] = mk(exp_cb, 1'b1, 1'b0, 1'b0, 32'd0, MEM_BASE, 64'd0);
      ring();
      chk("R3 copy count", 64'(cp_cnt), 64'(n));
      chk("R3 direction", 64'(cp_write), 64'd1);
      for (int i = 0; i < n; i++) begin
        chk("R3 src", src_log[i], {32'h8000_0000 | 32'(p), 32'(i * 64)});
        chk("R3 dst", dst_log[i], {32'h4000_0000 + 32'(p), 32'(i * 64 + 7)});
        chk("R3 len", 64'(len_log[i]), 64'((i + 1) * (p + 3)));
      end
      chk("R2 read count", 64'(rd_cnt), 64'(n + 1));
      for (int i = 0; i <= n; i++)
        chk("R2 read addr", rd_log[i], MEM_BASE + 64'(32 * i));
      chk("R6 irq_done on flagged last", 64'(irq_done), 64'd1);
      exp_cb = ~exp_cb;
      reg_read(3'd4, rv);
      chk("R5 cycle bit flipped, idle", 64'(rv), 64'({exp_cb, 2'b00}));
      reg_write(3'd3, 32'd1);
      @(negedge clk);
      chk("R9 done cleared by 1", 64'(irq_done), 64'd0);
    end

    // stale list: memory still holds the previous cycle bit
    ring();
    chk("R4 stale no copy", 64'(cp_cnt), 64'd0);
    chk("R4 stale one read", 64'(rd_cnt), 64'd1);
    chk("R4 stale read at base", rd_log[0], MEM_BASE);
    chk("R4 stale no irq", 64'({irq_done, irq_abort}), 64'd0);
    reg_read(3'd4, rv);
    chk("R4 stale status", 64'(rv), 64'({exp_cb, 2'b00}));

    // refill without interrupt flags
    mem[0] = mk(exp_cb, 1'b0, 1'b0, 1'b0, 32'd100, 64'h11, 64'h22);
    mem[1] = mk(exp_cb, 1'b0, 1'b0, 1'b0, 32'd200, 64'h33, 64'h44);
    mem[2] = mk(exp_cb, 1'b1, 1'b0, 1'b0, 32'd0, MEM_BASE, 64'd0);
    ring();
    chk("R4 refetch after refill", 64'(cp_cnt), 64'd2);
    chk("R4 refetch from base", rd_log[0], MEM_BASE);
    chk("R6 no flags no irq", 64'(irq_done), 64'd0);
    exp_cb = ~exp_cb;

    // zero length in the middle
    mem[0] = mk(exp_cb, 1'b0, 1'b1, 1'b0, 32'd5, 64'h55, 64'h66);
    mem[1] = mk(exp_cb, 1'b0, 1'b1, 1'b0, 32'd0, 64'h77, 64'h88);
    mem[2] = mk(exp_cb, 1'b0, 1'b0, 1'b0, 32'd9, 64'h99, 64'hAA);
    mem[3] = mk(exp_cb, 1'b1, 1'b0, 1'b0, 32'd0, 64'h1400, 64'd0);
    ring();
    chk("R7 one copy before fault", 64'(cp_cnt), 64'd1);
    chk("R7 two reads", 64'(rd_cnt), 64'd2);
    chk("R7 irq_abort", 64'(irq_abort), 64'd1);
    reg_read(3'd4, rv);
    chk("R7 error set, cycle bit kept", 64'(rv), 64'({exp_cb, 2'b10}));
    reg_write(3'd3, 32'd1);
    irq_done_clear: begin end
    ring();
    chk("R8 doorbell ignored on error", 64'(rd_cnt), 64'd0);
    reg_write(3'd3, 32'd1);
    @(negedge clk);
    chk("R9 zero bit leaves abort", 64'(irq_abort), 64'd1);
    reg_write(3'd3, 32'd2);
    @(negedge clk);
    chk("R8 abort cleared", 64'(irq_abort), 64'd0);
    reg_read(3'd4, rv);
    chk("R8 error cleared", 64'(rv), 64'({exp_cb, 2'b00}));

    // repaired list, maximum length, high address bits, relocated base
    mem[1] = mk(exp_cb, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF,
                64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF);
    ring();
    chk("R10 copy count", 64'(cp_cnt), 64'd3);
    chk("R10 max length", 64'(len_log[1]), 64'hFFFF_FFFF);
    chk("R10 wide src", src_log[1], 64'hFEDC_BA98_7654_3210);
    chk("R10 wide dst", dst_log[1], 64'h0123_4567_89AB_CDEF);
    reg_read(3'd0, rv);
    chk("R5 base low from link", 64'(rv), 64'h1400);
    reg_read(3'd1, rv);
    chk("R5 base high from link", 64'(rv), 64'd0);
    exp_cb = ~exp_cb;
    reg_read(3'd4, rv);
    chk("R5 cycle bit after link", 64'(rv), 64'({exp_cb, 2'b00}));
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule